// File: doc/BRIEF.md
# Scoreboard Hazard Tracking Controller

This block is the bookkeeping controller of an in-order-issue, out-of-order-execution pipeline built around a small set of functional units that have no forwarding path. Each cycle it may accept one decoded instruction, which names a target unit, an operation code, a destination register and two source registers. It keeps one status record per unit and a table that links every register to the unit that will write it. From that state it grants three kinds of permission: issue, operand read and result write. It also takes a completion pulse from each unit.

Instruction decode is split into two steps. The issue step checks the unit and the destination register. The operand-read step waits for true data dependences to clear, and operands always come from the register file. Result write is held back while an older instruction still has to read the old contents of the destination register. A later instruction that would write the same register is stopped at issue. The arithmetic, the register contents and the exception handling stay outside the block.

The default build has four units, indexed 0 integer, 1 multiplier, 2 adder and 3 divider, and sixteen registers. Inside the tables, a producing unit is held as a 3-bit identifier: the value 0 means no producer, and unit k is stored as k+1.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: `iss_grant` is high in the same cycle when `iss_valid` is high, the unit selected by `iss_fu` is idle and no pending writer targets `iss_dst`. An accepted instruction shows in `fu_busy` from the next cycle.
- R2: Issue is refused when the selected unit is busy. The refused instruction leaves that unit's record and the register table unchanged.
- R3: Issue is refused while any issued, not yet written instruction targets the same destination register. This includes the cycle in which that instruction holds its write grant.
- R4: A unit whose source register has a pending producer keeps `rd_grant` low. `rd_grant` rises in the cycle after the producer's `wr_grant` cycle.
- R5: A unit whose sources have no pending producer raises `rd_grant` in the cycle after issue. `rd_grant` is a one-cycle pulse, and the unit reads its operands in that cycle.
- R6: A `done` pulse to a unit that has read its operands raises `wr_grant` in the next cycle, unless a write-after-read hazard exists. A `done` pulse to a unit that is idle or still waiting for operands is ignored.
- R7: `wr_grant` is held low while any other busy unit has a ready, unread source equal to this unit's destination. It rises in the cycle after that reader's `rd_grant` pulse.
- R8: In the cycle after `wr_grant`, the unit is idle and its destination register is free for a new issue.
- R9: An instruction issued in the same cycle that its source's producer holds `wr_grant` treats that source as ready, so its `rd_grant` follows in the next cycle.
- R10: After reset every unit is idle, no register has a pending writer, and no grant is high.
- R11: While a unit is busy, its slot of `fu_op` (bits 4u+3 down to 4u for unit u) holds the operation code it was issued with.
- R12: Two units with different destinations that both complete can hold `wr_grant` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Decoded instruction offered for issue |
| iss_fu | input | 2 | Target unit index (0 int, 1 mul, 2 add, 3 div) |
| iss_op | input | 4 | Operation code for the unit |
| iss_dst | input | 4 | Destination register |
| iss_src1 | input | 4 | First source register |
| iss_src2 | input | 4 | Second source register |
| done | input | 4 | Per-unit completion pulse |
| iss_grant | output | 1 | Offered instruction is accepted this cycle |
| rd_grant | output | 4 | Per-unit permission to read operands this cycle |
| wr_grant | output | 4 | Per-unit permission to write its result this cycle |
| fu_busy | output | 4 | Per-unit busy flag |
| fu_op | output | 16 | Per-unit pending operation code, 4 bits per unit |

## Verification
`iss_grant` is a combinational function of the offered instruction and the current state, so it is due in the cycle of the offer. `fu_busy` follows one cycle later. `rd_grant` is due one cycle after issue when the sources are free, or one cycle after the producer's write grant when they are not. `wr_grant` is due one cycle after `done`, or one cycle after the last blocking reader's read pulse. The bench drives inputs just after the falling edge and samples outputs a step later. Each check is placed on the exact falling edge that this count of register stages predicts. In the cycles before that edge it also checks that the grant is still low.

// File: rtl/sb_pkg.sv
package sb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_WAIT_OPS = 2'd1,
      ST_EXEC     = 2'd2,
      ST_DONE     = 2'd3
   } sb_stage_e;

endpackage

// File: rtl/sb_regstat.sv
module sb_regstat #(
   parameter int NUM_FU  = 4,
   parameter int NUM_REG = 16,
   parameter int ID_W    = 3,
   parameter int REG_W   = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     set_en,
   input  logic [REG_W-1:0]         set_reg,
   input  logic [ID_W-1:0]          set_id,
   input  logic [NUM_FU-1:0]        clr_en,
   input  logic [NUM_FU*REG_W-1:0]  clr_reg,
   input  logic [REG_W-1:0]         look_dst,
   input  logic [REG_W-1:0]         look_s1,
   input  logic [REG_W-1:0]         look_s2,
   output logic [ID_W-1:0]          id_dst,
   output logic [ID_W-1:0]          id_s1,
   output logic [ID_W-1:0]          id_s2
);

   logic [ID_W-1:0]    tab [NUM_REG];
   logic [NUM_REG-1:0] clr_hit;

   always_comb begin
      clr_hit = '0;
      for (int u = 0; u < NUM_FU; u++) begin
         if (clr_en[u]) clr_hit[clr_reg[u*REG_W +: REG_W]] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < NUM_REG; r++) tab[r] <= '0;
      end else begin
         for (int r = 0; r < NUM_REG; r++) begin
            if (set_en && (set_reg == REG_W'(r))) tab[r] <= set_id;
            else if (clr_hit[r])                  tab[r] <= '0;
         end
      end
   end

   assign id_dst = tab[look_dst];
   assign id_s1  = tab[look_s1];
   assign id_s2  = tab[look_s2];

   AST_SET_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> (tab[set_reg] == '0));  // R3

   for (genvar u = 0; u < NUM_FU; u++) begin : g_own
      AST_CLEAR_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
         clr_en[u] |-> (tab[clr_reg[u*REG_W +: REG_W]] == ID_W'(u + 1)));  // R8
   end

endmodule

// File: rtl/sb_fu_slot.sv
module sb_fu_slot
   import sb_pkg::*;
#(
   parameter int NUM_FU = 4,
   parameter int ID_W   = 3,
   parameter int REG_W  = 4,
   parameter int OP_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_en,
   input  logic [OP_W-1:0]   iss_op,
   input  logic [REG_W-1:0]  iss_dst,
   input  logic [REG_W-1:0]  iss_s1,
   input  logic [REG_W-1:0]  iss_s2,
   input  logic [ID_W-1:0]   iss_q1,
   input  logic [ID_W-1:0]   iss_q2,
   input  logic [NUM_FU-1:0] wr_bcast,
   input  logic              done_i,
   input  logic              wr_ok,
   output logic              busy_o,
   output logic              rd_grant_o,
   output logic              wr_grant_o,
   output logic [OP_W-1:0]   op_o,
   output logic [REG_W-1:0]  dst_o,
   output logic [REG_W-1:0]  s1_o,
   output logic [REG_W-1:0]  s2_o,
   output logic              r1_o,
   output logic              r2_o
);

   localparam int ID_N = 1 << ID_W;

   sb_stage_e        stage;
   logic [ID_W-1:0]  q1, q2;
   logic [ID_N-1:0]  bc_id;

   // index by identifier: slot 0 means "no producer" and never fires
   assign bc_id = ID_N'({wr_bcast, 1'b0});

   assign busy_o     = (stage != ST_IDLE);
   assign rd_grant_o = (stage == ST_WAIT_OPS) && r1_o && r2_o;
   assign wr_grant_o = (stage == ST_DONE) && wr_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage <= ST_IDLE;
         op_o  <= '0;
         dst_o <= '0;
         s1_o  <= '0;
         s2_o  <= '0;
         q1    <= '0;
         q2    <= '0;
         r1_o  <= 1'b0;
         r2_o  <= 1'b0;
      end else begin
         unique case (stage)
            ST_IDLE: if (issue_en) begin
               stage <= ST_WAIT_OPS;
               op_o  <= iss_op;
               dst_o <= iss_dst;
               s1_o  <= iss_s1;
               s2_o  <= iss_s2;
               q1    <= iss_q1;
               q2    <= iss_q2;
               r1_o  <= (iss_q1 == '0);
               r2_o  <= (iss_q2 == '0);
            end
            ST_WAIT_OPS: if (rd_grant_o) begin
               stage <= ST_EXEC;
               r1_o  <= 1'b0;
               r2_o  <= 1'b0;
            end else begin
               if (bc_id[q1]) begin
                  r1_o <= 1'b1;
                  q1   <= '0;
               end
               if (bc_id[q2]) begin
                  r2_o <= 1'b1;
                  q2   <= '0;
               end
            end
            ST_EXEC: if (done_i) stage <= ST_DONE;
            ST_DONE: if (wr_grant_o) begin
               stage <= ST_IDLE;
               q1    <= '0;
               q2    <= '0;
            end
            default: stage <= ST_IDLE;
         endcase
      end
   end

   AST_ISSUE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      issue_en |-> (stage == ST_IDLE));  // R2

   AST_READ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_grant_o |=> ((stage == ST_EXEC) && !r1_o && !r2_o && !rd_grant_o));  // R5

   AST_WAIT_HAS_PRODUCER: assert property (@(posedge clk) disable iff (!rst_n)
      ((stage == ST_WAIT_OPS) && !r1_o) |-> (q1 != '0));  // R4

   AST_WRITE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_grant_o |=> !busy_o);  // R8

endmodule

// File: rtl/sb_war_check.sv
module sb_war_check #(
   parameter int NUM_FU = 4,
   parameter int REG_W  = 4
) (
   input  logic [NUM_FU*REG_W-1:0] dst_f,
   input  logic [NUM_FU*REG_W-1:0] s1_f,
   input  logic [NUM_FU*REG_W-1:0] s2_f,
   input  logic [NUM_FU-1:0]       r1,
   input  logic [NUM_FU-1:0]       r2,
   output logic [NUM_FU-1:0]       wr_ok
);

   for (genvar u = 0; u < NUM_FU; u++) begin : g_writer
      logic [NUM_FU-1:0] block;
      for (genvar v = 0; v < NUM_FU; v++) begin : g_reader
         if (v == u) begin : g_self
            assign block[v] = 1'b0;
         end else begin : g_other
            assign block[v] =
               (r1[v] && (s1_f[v*REG_W +: REG_W] == dst_f[u*REG_W +: REG_W])) ||
               (r2[v] && (s2_f[v*REG_W +: REG_W] == dst_f[u*REG_W +: REG_W]));
         end
      end
      assign wr_ok[u] = ~|block;
   end

endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl #(
   parameter int NUM_FU  = 4,
   parameter int NUM_REG = 16,
   parameter int OP_W    = 4,
   localparam int FU_SEL_W = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
   localparam int REG_W    = $clog2(NUM_REG)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   iss_valid,
   input  logic [FU_SEL_W-1:0]    iss_fu,
   input  logic [OP_W-1:0]        iss_op,
   input  logic [REG_W-1:0]       iss_dst,
   input  logic [REG_W-1:0]       iss_src1,
   input  logic [REG_W-1:0]       iss_src2,
   input  logic [NUM_FU-1:0]      done,
   output logic                   iss_grant,
   output logic [NUM_FU-1:0]      rd_grant,
   output logic [NUM_FU-1:0]      wr_grant,
   output logic [NUM_FU-1:0]      fu_busy,
   output logic [NUM_FU*OP_W-1:0] fu_op
);

   localparam int ID_W = $clog2(NUM_FU + 1);
   localparam int ID_N = 1 << ID_W;

   if (NUM_FU < 2 || (1 << FU_SEL_W) != NUM_FU) begin : g_bad_fu
      $error("NUM_FU must be a power of two of at least 2");
   end
   if (NUM_REG < 2 || (1 << REG_W) != NUM_REG) begin : g_bad_reg
      $error("NUM_REG must be a power of two of at least 2");
   end
   if (OP_W < 1) begin : g_bad_op
      $error("OP_W must be positive");
   end

   logic [ID_W-1:0]         id_dst, id_s1, id_s2;
   logic [ID_W-1:0]         q1_new, q2_new;
   logic [ID_N-1:0]         bc_id;
   logic [NUM_FU*REG_W-1:0] dst_f, s1_f, s2_f;
   logic [NUM_FU-1:0]       r1, r2, wr_ok;

   assign bc_id     = ID_N'({wr_grant, 1'b0});
   assign iss_grant = iss_valid && !fu_busy[iss_fu] && (id_dst == '0);

   // a producer writing in this very cycle counts as already written
   assign q1_new = bc_id[id_s1] ? '0 : id_s1;
   assign q2_new = bc_id[id_s2] ? '0 : id_s2;

   sb_regstat #(
      .NUM_FU (NUM_FU),
      .NUM_REG(NUM_REG),
      .ID_W   (ID_W),
      .REG_W  (REG_W)
   ) u_regstat (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (iss_grant),
      .set_reg (iss_dst),
      .set_id  (ID_W'(iss_fu) + ID_W'(1)),
      .clr_en  (wr_grant),
      .clr_reg (dst_f),
      .look_dst(iss_dst),
      .look_s1 (iss_src1),
      .look_s2 (iss_src2),
      .id_dst  (id_dst),
      .id_s1   (id_s1),
      .id_s2   (id_s2)
   );

   for (genvar u = 0; u < NUM_FU; u++) begin : g_slot
      sb_fu_slot #(
         .NUM_FU(NUM_FU),
         .ID_W  (ID_W),
         .REG_W (REG_W),
         .OP_W  (OP_W)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .issue_en  (iss_grant && (iss_fu == FU_SEL_W'(u))),
         .iss_op    (iss_op),
         .iss_dst   (iss_dst),
         .iss_s1    (iss_src1),
         .iss_s2    (iss_src2),
         .iss_q1    (q1_new),
         .iss_q2    (q2_new),
         .wr_bcast  (wr_grant),
         .done_i    (done[u]),
         .wr_ok     (wr_ok[u]),
         .busy_o    (fu_busy[u]),
         .rd_grant_o(rd_grant[u]),
         .wr_grant_o(wr_grant[u]),
         .op_o      (fu_op[u*OP_W +: OP_W]),
         .dst_o     (dst_f[u*REG_W +: REG_W]),
         .s1_o      (s1_f[u*REG_W +: REG_W]),
         .s2_o      (s2_f[u*REG_W +: REG_W]),
         .r1_o      (r1[u]),
         .r2_o      (r2[u])
      );
   end

   sb_war_check #(
      .NUM_FU(NUM_FU),
      .REG_W (REG_W)
   ) u_war (
      .dst_f(dst_f),
      .s1_f (s1_f),
      .s2_f (s2_f),
      .r1   (r1),
      .r2   (r2),
      .wr_ok(wr_ok)
   );

   AST_ISSUE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      iss_grant |=> fu_busy[$past(iss_fu)]);  // R1

   for (genvar u = 0; u < NUM_FU; u++) begin : g_war_chk
      for (genvar v = 0; v < NUM_FU; v++) begin : g_pair
         if (u != v) begin : g_diff
            AST_NO_WRITE_UNDER_READ: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_grant[u] && rd_grant[v]) |->
                  ((s1_f[v*REG_W +: REG_W] != dst_f[u*REG_W +: REG_W]) &&
                   (s2_f[v*REG_W +: REG_W] != dst_f[u*REG_W +: REG_W])));  // R7
         end
      end
   end

endmodule

// File: tb/sb_hazard_ctrl_bench.sv
module sb_hazard_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_valid = 1'b0;
   logic [1:0]  iss_fu = '0;
   logic [3:0]  iss_op = '0;
   logic [3:0]  iss_dst = '0;
   logic [3:0]  iss_src1 = '0;
   logic [3:0]  iss_src2 = '0;
   logic [3:0]  done = '0;
   logic        iss_grant;
   logic [3:0]  rd_grant, wr_grant, fu_busy;
   logic [15:0] fu_op;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   sb_hazard_ctrl u_sb_hazard_ctrl (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_fu(iss_fu),
      .iss_op(iss_op), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
      .done(done), .iss_grant(iss_grant), .rd_grant(rd_grant), .wr_grant(wr_grant),
      .fu_busy(fu_busy), .fu_op(fu_op)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      #1;
      iss_valid = 1'b0;
      done = '0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      iss_valid = 1'b0;
      done = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic offer(input logic [1:0] fu, input logic [3:0] op, input logic [3:0] d,
                        input logic [3:0] a, input logic [3:0] b, input logic exp,
                        input string tag);
      iss_valid = 1'b1;
      iss_fu = fu; iss_op = op; iss_dst = d; iss_src1 = a; iss_src2 = b;
      #1;
      check(tag, iss_grant, exp);
   endtask

   task automatic t_reset();
      do_reset();
      check("R10 busy after reset", fu_busy, 4'h0);
      check("R10 rd_grant after reset", rd_grant, 4'h0);
      check("R10 wr_grant after reset", wr_grant, 4'h0);
      check("R10 no grant with no offer", iss_grant, 1'b0);
      offer(2'd3, 4'h1, 4'd15, 4'd0, 4'd1, 1'b1, "R10 register table empty");
      cyc();
   endtask

   task automatic t_basic();
      do_reset();
      offer(2'd0, 4'h5, 4'd1, 4'd2, 4'd3, 1'b1, "R1 issue to idle unit");
      cyc();
      check("R1 busy next cycle", fu_busy, 4'b0001);
      check("R11 op held", fu_op[3:0], 4'h5);
      check("R5 read grant cycle after issue", rd_grant, 4'b0001);
      done = 4'b0101;                     // ignored: unit 0 waiting, unit 2 idle
      cyc();
      check("R5 read grant is one pulse", rd_grant, 4'b0000);
      cyc();
      check("R6 early done ignored", wr_grant, 4'b0000);
      check("R6 done on idle unit ignored", fu_busy, 4'b0001);
      done = 4'b0001;
      cyc();
      check("R6 write grant after done", wr_grant, 4'b0001);
      cyc();
      check("R8 unit idle after write", fu_busy, 4'b0000);
      check("R8 write grant dropped", wr_grant, 4'b0000);
   endtask

   task automatic t_struct();
      do_reset();
      offer(2'd1, 4'h9, 4'd1, 4'd2, 4'd3, 1'b1, "R1 issue to multiplier");
      cyc();
      offer(2'd1, 4'h3, 4'd4, 4'd5, 4'd6, 1'b0, "R2 busy unit refuses");
      cyc();
      check("R2 op of refused not loaded", fu_op[7:4], 4'h9);
      offer(2'd2, 4'h2, 4'd4, 4'd0, 4'd0, 1'b1, "R2 refused dest left free");
      cyc();
      check("R2 busy set", fu_busy, 4'b0110);
   endtask

   task automatic t_waw();
      do_reset();
      offer(2'd0, 4'h1, 4'd7, 4'd0, 4'd1, 1'b1, "R1 issue writer of r7");
      cyc();
      offer(2'd2, 4'h2, 4'd7, 4'd2, 4'd3, 1'b0, "R3 second writer of r7 refused");
      cyc();
      check("R3 refused unit stays idle", fu_busy, 4'b0001);
      done = 4'b0001;
      cyc();
      check("R6 write grant", wr_grant, 4'b0001);
      offer(2'd2, 4'h2, 4'd7, 4'd2, 4'd3, 1'b0, "R3 refused during write grant");
      cyc();
      offer(2'd2, 4'h2, 4'd7, 4'd2, 4'd3, 1'b1, "R8 dest free after write");
      cyc();
   endtask

   task automatic t_raw();
      do_reset();
      offer(2'd1, 4'h4, 4'd5, 4'd1, 4'd2, 1'b1, "R1 producer of r5");
      cyc();
      offer(2'd2, 4'h6, 4'd6, 4'd5, 4'd3, 1'b1, "R1 consumer of r5");
      cyc();
      check("R4 consumer waits", rd_grant[2], 1'b0);
      done = 4'b0010;
      cyc();
      check("R4 producer write grant", wr_grant, 4'b0010);
      check("R4 consumer still waits", rd_grant[2], 1'b0);
      cyc();
      check("R4 consumer read after producer write", rd_grant, 4'b0100);
      check("R8 producer idle", fu_busy, 4'b0100);
   endtask

   task automatic t_war();
      do_reset();
      offer(2'd1, 4'h1, 4'd2, 4'd1, 4'd1, 1'b1, "R1 long producer of r2");
      cyc();
      offer(2'd2, 4'h2, 4'd3, 4'd2, 4'd4, 1'b1, "R1 reader of r4 blocked on r2");
      cyc();
      offer(2'd0, 4'h3, 4'd4, 4'd5, 4'd6, 1'b1, "R1 writer of r4");
      cyc();
      check("R5 writer reads", rd_grant, 4'b0001);
      cyc();
      done = 4'b0001;
      cyc();
      check("R7 write held by unread r4", wr_grant, 4'b0000);
      done = 4'b0010;
      cyc();
      check("R7 held, producer granted", wr_grant, 4'b0010);
      cyc();
      check("R4 reader released", rd_grant, 4'b0100);
      check("R7 still held while reader reads", wr_grant[0], 1'b0);
      cyc();
      check("R7 write granted after read", wr_grant, 4'b0001);
      cyc();
   endtask

   task automatic t_bypass();
      do_reset();
      offer(2'd1, 4'h1, 4'd5, 4'd1, 4'd2, 1'b1, "R1 producer");
      cyc();
      cyc();
      done = 4'b0010;
      cyc();
      check("R6 producer write grant", wr_grant, 4'b0010);
      offer(2'd2, 4'h2, 4'd6, 4'd5, 4'd5, 1'b1, "R9 issue during producer write");
      cyc();
      check("R9 read grant next cycle", rd_grant, 4'b0100);
   endtask

   task automatic t_dual();
      do_reset();
      offer(2'd0, 4'h1, 4'd1, 4'd2, 4'd3, 1'b1, "R1 first unit");
      cyc();
      offer(2'd3, 4'h2, 4'd4, 4'd5, 4'd6, 1'b1, "R1 divider");
      cyc();
      cyc();
      done = 4'b1001;
      cyc();
      check("R12 both write grants", wr_grant, 4'b1001);
      cyc();
      check("R12 both idle", fu_busy, 4'b0000);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_basic();
      t_struct();
      t_waw();
      t_raw();
      t_war();
      t_bypass();
      t_dual();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule